// File: doc/BRIEF.md
# Serial Flash Status-Register Command Slave

This block is the SPI-facing command slave that owns the status register of a serial memory. It watches a mode-0 SPI bus (chip select, serial clock, serial data in, serial data out), oversamples it with the system clock, and decodes three instructions: write enable, read status and write status. It holds the write-enable latch, the write-in-progress flag, three block-protect bits and a status-register write-disable bit. It also runs a self-timed status write cycle whose length is a parameter counted in system clocks.

A write-status frame takes effect only when all of these hold: the enable latch was set by an earlier frame, chip select rises right after the sixteenth bit, no cycle is already running, and the register is not locked by its write-disable bit together with a low write-protect pin. The new protect and write-disable values are committed when the busy cycle ends. At that same moment the busy flag and the enable latch both drop. A device reset pin held low stops new commands and clears the enable latch. It does not cut a running cycle short.

Top module: `sfs_status_slave`

## Requirements
- R1: A frame made of exactly the 8 bits 0x06 (MSB first, sampled on rising serial clock) sets the enable latch (status bit 1) when chip select rises, unless a busy cycle is running.
- R2: After the 8-bit code 0x05, serial data out shifts the status register MSB first, one bit per falling clock edge. It reloads the live register value at each byte boundary for as long as chip select stays low.
- R3: A write-status frame (code 0x01 followed by one data byte) is discarded when the enable latch is 0.
- R4: A write-status frame counts only when chip select rises after exactly 16 bits. With 15 or 17 bits it has no effect, and the enable latch keeps its value.
- R5: An accepted status write sets the busy flag (status bit 0) for BUSY_CYCLES system clocks. When the cycle ends, the busy flag and the enable latch clear together, and the new protect values appear.
- R6: A status write changes only bit 7 (write-disable) and bits 4..2 (protect). Bits 6 and 5 always read 0, and data bits 6, 5, 1 and 0 are ignored.
- R7: When bit 7 is 1 and wp_n is low, a status write is ignored and the enable latch stays 1. When wp_n is high, the write proceeds.
- R8: During a busy cycle, read status is still served and shows the busy flag as 1. A write-status frame sent during the cycle is ignored.
- R9: dev_rst_n low during a busy cycle lets the cycle complete and commit. When no cycle is running, dev_rst_n low clears the enable latch and causes commands to be ignored.
- R10: sdo_oe is 0 whenever chip select is high.
- R11: After rst, the status register reads 0x00 and sdo_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst | input | 1 | Synchronous active-high system reset |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock, mode 0 |
| sdi | input | 1 | SPI serial data in |
| wp_n | input | 1 | Write-protect pin, active low |
| dev_rst_n | input | 1 | Device reset pin, active low |
| sdo | output | 1 | SPI serial data out |
| sdo_oe | output | 1 | Output enable for sdo (0 means high impedance) |

## Verification
On every cycle, the assertions check four relations. A rising busy flag must follow a set enable latch. A falling busy flag must come with a cleared latch. The protect bits must not move while busy. A busy cycle must never start while the register is locked and wp_n is low. They also check that the output enable is off while chip select is high. Only the bench scenarios can show the behaviour seen from the bus. These cover frame-length rejection at 15 and 17 bits, the exact bit mask applied to the data byte, the streamed and repeated read bytes, the old protect value staying visible during the cycle, and the device reset completing a cycle rather than aborting it.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam int B_SRWD  = 7;
  localparam int B_BP_HI = 4;
  localparam int B_BP_LO = 2;
  localparam int B_WEL   = 1;
  localparam int B_WIP   = 0;
  localparam int BP_W    = B_BP_HI - B_BP_LO + 1;
endpackage

// File: rtl/sfs_sync.sv
module sfs_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= INIT;
      q    <= INIT;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/sfs_frame.sv
module sfs_frame
  import sfs_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            cs_n_s,
  input  logic            sck_s,
  input  logic            sdi_s,
  input  logic            hold,
  input  logic [7:0]      status,
  output logic [7:0]      opcode,
  output logic            wr_srwd,
  output logic [BP_W-1:0] wr_bp,
  output logic            frame_end,
  output logic            len8,
  output logic            len16,
  output logic            sdo,
  output logic            sdo_oe
);
  logic       sck_d, cs_d;
  logic [6:0] sh;
  logic [2:0] bitpos;
  logic [1:0] nbytes;
  logic [7:0] out_sh;
  logic       sck_rise, sck_fall;

  assign sck_rise  = sck_s & ~sck_d & ~cs_n_s;
  assign sck_fall  = ~sck_s & sck_d & ~cs_n_s;
  assign frame_end = cs_n_s & ~cs_d;
  assign len8      = (nbytes == 2'd1) && (bitpos == 3'd0);
  assign len16     = (nbytes == 2'd2) && (bitpos == 3'd0);
  assign sdo       = out_sh[7];

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d <= 1'b0; cs_d <= 1'b1; sh <= '0; bitpos <= '0; nbytes <= '0;
      opcode <= '0; wr_srwd <= 1'b0; wr_bp <= '0; out_sh <= '0; sdo_oe <= 1'b0;
    end else begin
      sck_d  <= sck_s;
      cs_d   <= cs_n_s;
      sdo_oe <= ~cs_n_s;
      if (cs_n_s || hold) begin
        bitpos <= '0;
        nbytes <= '0;
        out_sh <= '0;
      end else begin
        if (sck_rise) begin
          sh     <= {sh[5:0], sdi_s};
          bitpos <= bitpos + 3'd1;
          if (bitpos == 3'd7) begin
            if (nbytes != 2'd3) nbytes <= nbytes + 2'd1;
            if (nbytes == 2'd0) opcode <= {sh, sdi_s};
            if (nbytes == 2'd1) begin
              wr_srwd <= sh[B_SRWD-1];
              wr_bp   <= sh[B_BP_HI-1:B_BP_LO-1];
            end
          end
        end
        if (sck_fall) begin
          if (nbytes != 2'd0 && bitpos == 3'd0)
            out_sh <= (opcode == OP_RDSR) ? status : 8'h00;
          else
            out_sh <= {out_sh[6:0], 1'b0};
        end
      end
    end
  end

  a_r10_oe_off_when_deselected: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> !sdo_oe);
endmodule

// File: rtl/sfs_status.sv
module sfs_status
  import sfs_pkg::*;
#(
  parameter int BUSY_CYCLES = 2000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hold,
  input  logic            wp_n_s,
  input  logic            frame_end,
  input  logic            len8,
  input  logic            len16,
  input  logic [7:0]      opcode,
  input  logic            wr_srwd,
  input  logic [BP_W-1:0] wr_bp,
  output logic [7:0]      status
);
  localparam int CW = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(BUSY_CYCLES - 1);

  logic            srwd, wel, wip, locked;
  logic [BP_W-1:0] bp, pend_bp;
  logic            pend_srwd;
  logic [CW-1:0]   cnt;

  assign locked = srwd & ~wp_n_s;

  always_comb begin
    status = 8'h00;
    status[B_SRWD]          = srwd;
    status[B_BP_HI:B_BP_LO] = bp;
    status[B_WEL]           = wel;
    status[B_WIP]           = wip;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      srwd <= 1'b0; bp <= '0; wel <= 1'b0; wip <= 1'b0;
      pend_srwd <= 1'b0; pend_bp <= '0; cnt <= '0;
    end else if (wip) begin
      if (cnt == LAST) begin
        wip  <= 1'b0;
        wel  <= 1'b0;
        srwd <= pend_srwd;
        bp   <= pend_bp;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (hold) begin
      wel <= 1'b0;
    end else if (frame_end) begin
      if (len8 && opcode == OP_WREN) wel <= 1'b1;
      if (len16 && opcode == OP_WRSR && wel && !locked) begin
        wip       <= 1'b1;
        pend_srwd <= wr_srwd;
        pend_bp   <= wr_bp;
        cnt       <= '0;
      end
    end
  end

  a_r3_busy_needs_latch: assert property (@(posedge clk) disable iff (rst)
    $rose(wip) |-> $past(wel));
  a_r5_latch_drops_with_busy: assert property (@(posedge clk) disable iff (rst)
    $fell(wip) |-> !wel);
  a_r8_protect_frozen_busy: assert property (@(posedge clk) disable iff (rst)
    wip |-> $stable({srwd, bp}));
  a_r7_no_start_when_locked: assert property (@(posedge clk) disable iff (rst)
    $rose(wip) |-> $past(!locked));
endmodule

// File: rtl/sfs_status_slave.sv
module sfs_status_slave
  import sfs_pkg::*;
#(
  parameter int BUSY_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic sdi,
  input  logic wp_n,
  input  logic dev_rst_n,
  output logic sdo,
  output logic sdo_oe
);
  logic            cs_n_s, sck_s, sdi_s, wp_n_s, dev_rst_n_s;
  logic [7:0]      opcode, status;
  logic            wr_srwd, frame_end, len8, len16;
  logic [BP_W-1:0] wr_bp;

  sfs_sync #(.W(5), .INIT(5'b10011)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cs_n, sck, sdi, wp_n, dev_rst_n}),
    .q   ({cs_n_s, sck_s, sdi_s, wp_n_s, dev_rst_n_s})
  );

  sfs_frame u_frame (
    .clk       (clk),
    .rst       (rst),
    .cs_n_s    (cs_n_s),
    .sck_s     (sck_s),
    .sdi_s     (sdi_s),
    .hold      (~dev_rst_n_s),
    .status    (status),
    .opcode    (opcode),
    .wr_srwd   (wr_srwd),
    .wr_bp     (wr_bp),
    .frame_end (frame_end),
    .len8      (len8),
    .len16     (len16),
    .sdo       (sdo),
    .sdo_oe    (sdo_oe)
  );

  sfs_status #(.BUSY_CYCLES(BUSY_CYCLES)) u_status (
    .clk       (clk),
    .rst       (rst),
    .hold      (~dev_rst_n_s),
    .wp_n_s    (wp_n_s),
    .frame_end (frame_end),
    .len8      (len8),
    .len16     (len16),
    .opcode    (opcode),
    .wr_srwd   (wr_srwd),
    .wr_bp     (wr_bp),
    .status    (status)
  );
endmodule

// File: tb/sfs_status_slave_test.sv
module sfs_status_slave_test;
  localparam int BUSY = 1000;
  localparam int H = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, wp_n = 1'b1, dev_rst_n = 1'b1;
  logic sdo, sdo_oe;
  int n_checks = 0, n_fail = 0;
  bit finished = 1'b0;

  typedef struct { logic [7:0] val; string tag; } exp_t;
  exp_t       exp_q[$];
  logic [7:0] got_q[$];

  always #10 clk = ~clk;

  sfs_status_slave #(.BUSY_CYCLES(BUSY)) uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .wp_n(wp_n), .dev_rst_n(dev_rst_n), .sdo(sdo), .sdo_oe(sdo_oe));

  task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [23:0] tx, input int nbits, output logic [23:0] rx);
    rx = '0;
    cs_n = 1'b0;
    waitc(H);
    for (int i = 0; i < nbits; i++) begin
      sdi = tx[23-i];
      waitc(H);
      rx[23-i] = sdo;
      sck = 1'b1;
      waitc(H);
      sck = 1'b0;
    end
    waitc(H);
    cs_n = 1'b1;
    waitc(2*H);
  endtask

  task automatic send(input logic [23:0] tx, input int nbits);
    logic [23:0] rx;
    xfer(tx, nbits, rx);
  endtask

  task automatic expect_b(input logic [7:0] v, input string tag);
    exp_t e;
    e.val = v; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic read_status(input int nb);
    logic [23:0] rx;
    xfer({8'h05, 16'h0000}, 8 + 8*nb, rx);
    got_q.push_back(rx[15:8]);
    if (nb > 1) got_q.push_back(rx[7:0]);
  endtask

  task automatic wren();
    send({8'h06, 16'h0}, 8);
  endtask

  task automatic wrsr(input logic [7:0] d, input int nbits);
    send({8'h01, d, 8'h00}, nbits);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (got_q.size() > 0 && exp_q.size() > 0) begin
        exp_t e;
        logic [7:0] g;
        e = exp_q.pop_front();
        g = got_q.pop_front();
        check(g, e.val, e.tag);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    waitc(5);
    rst = 1'b0;
    waitc(5);
    check({7'b0, sdo_oe}, 8'h00, "R11 sdo_oe after reset");
    expect_b(8'h00, "R11 status after reset");
    read_status(1);
    check({7'b0, sdo_oe}, 8'h00, "R10 sdo_oe with cs high");

    wrsr(8'h9C, 16);
    expect_b(8'h00, "R3 write without latch ignored");
    read_status(1);

    wren();
    expect_b(8'h02, "R1 latch set");
    expect_b(8'h02, "R2 repeated byte");
    read_status(2);

    wrsr(8'h9C, 15);
    expect_b(8'h02, "R4 15-bit frame ignored");
    read_status(1);
    send({8'h01, 8'h9C, 8'h00}, 17);
    expect_b(8'h02, "R4 17-bit frame ignored");
    read_status(1);

    wrsr(8'hFF, 16);
    expect_b(8'h03, "R8 busy visible old protect");
    read_status(1);
    wrsr(8'h00, 16);
    waitc(BUSY + 200);
    expect_b(8'h9C, "R5 R6 committed masked value");
    read_status(1);

    wp_n = 1'b0;
    wren();
    wrsr(8'h00, 16);
    expect_b(8'h9E, "R7 locked write ignored");
    read_status(1);
    wp_n = 1'b1;
    wrsr(8'h00, 16);
    waitc(BUSY + 200);
    expect_b(8'h00, "R7 unlocked write done");
    read_status(1);

    wren();
    wrsr(8'h14, 16);
    waitc(50);
    dev_rst_n = 1'b0;
    waitc(BUSY + 200);
    dev_rst_n = 1'b1;
    waitc(10);
    expect_b(8'h14, "R9 cycle completes under reset");
    read_status(1);

    wren();
    expect_b(8'h16, "R1 latch set again");
    read_status(1);
    dev_rst_n = 1'b0;
    waitc(20);
    dev_rst_n = 1'b1;
    waitc(10);
    expect_b(8'h14, "R9 reset clears latch");
    read_status(1);

    dev_rst_n = 1'b0;
    waitc(10);
    wren();
    dev_rst_n = 1'b1;
    waitc(10);
    expect_b(8'h14, "R9 command ignored in reset");
    read_status(1);

    waitc(20);
    if (exp_q.size() != 0 || got_q.size() != 0) begin
      n_checks++; n_fail++;
      $display("FAIL scoreboard: got %0d left expected 0", exp_q.size() + got_q.size());
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule